// File: doc/BRIEF.md
# Wait/Hold Programmable Clock Divider

This block derives a slower clock from a domain source clock. The division ratio comes from two small counts. The wait count sets how long the output stays high, and the hold count sets how long it stays low. One output period lasts wait + hold + 2 source cycles. A bypass bit routes the source clock straight to the output.

Software writes a 32-bit configuration word. The counts in that word stay pending until software also sets the update-request bit. The divider then loads the new counts at the end of the low phase of the current period. In the same cycle it clears the request bit, so software polls that bit until it reads 0.

A sequencer with three named states generates the output:
- PH_HIGH drives the output high. It moves to PH_LOW after wait + 1 cycles.
- PH_LOW drives the output low. After hold + 1 cycles it reaches a period boundary. From there it moves to PH_PASS if bypass is requested, and otherwise to PH_HIGH.
- PH_PASS forwards the source clock. Every cycle in this state is a boundary. It moves to PH_HIGH once bypass is cleared.

Pending counts are loaded only at a boundary. The count width is a parameter: 4 bits for the standard variant, 3 bits for the narrow variant.

Top module: `wh_clock_divider`

## Requirements
- R1: After reset the configuration word reads 0, so wait = 0, hold = 0, bypass is off and no update is pending. The output divides by 2: high for 1 cycle, then low for 1 cycle.
- R2: The wait count sits in bits [16 +: CNT_W] and the hold count in bits [20 +: CNT_W]. Bypass is bit 24 and update-request is bit 25. All other bits, including count bits above CNT_W, read as 0. The read value changes only on a write or when an update is applied.
- R3: With active counts W and H, the output is high for W+1 source cycles and low for H+1 source cycles, a period of W+H+2.
- R4: Writing new counts with bit 25 clear leaves the output period unchanged, while the new counts read back at once.
- R5: A write with bit 25 set makes bit 25 read 1 from the next cycle. The new counts start at the end of the current low phase, and bit 25 clears in that same cycle and at no other time.
- R6: While bit 24 is set, the output follows the source clock. Bypass is entered only after a low phase completes. On leaving bypass, the output starts with a full high phase of W+1 cycles.
- R7: While in bypass, a pending update is applied, and bit 25 cleared, on the next source cycle.
- R8: With CNT_W = 3, count writes keep only bits [2:0]. The largest ratio is 16 (wait = 7, hold = 7 gives 8 high and 8 low).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Domain source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write word |
| cfg_rdata | output | 32 | Configuration read word |
| clk_out | output | 1 | Divided or bypassed clock |

## Verification
The bench writes counts without a request and confirms the period holds. A design that applied counts on every write would change the period at once. It polls the request bit, then measures whole periods for random ratios from 2 to 32. This catches a swapped wait/hold field or an off-by-one phase length. It also catches a request bit that clears before the load, because the next period would then still use the old ratio.

In bypass, it checks that the output follows both source clock levels, and that a pending update clears within one cycle. After leaving bypass, the first measured period must use the counts loaded during bypass. The narrow variant is driven with all-ones counts. A field that is not masked would read back an extra bit and stretch each phase beyond 8 cycles.

// File: rtl/wh_div_pkg.sv
package wh_div_pkg;
    typedef enum logic [1:0] {
        PH_HIGH = 2'd0,
        PH_LOW  = 2'd1,
        PH_PASS = 2'd2
    } ph_e;

    localparam int WAIT_LSB = 16;
    localparam int HOLD_LSB = 20;
    localparam int BYP_BIT  = 24;
    localparam int UPD_BIT  = 25;
    localparam int WORD_W   = 32;
endpackage

// File: rtl/wh_div_regs.sv
module wh_div_regs
    import wh_div_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              apply,
    output logic [CNT_W-1:0]  wait_q,
    output logic [CNT_W-1:0]  hold_q,
    output logic              byp_q,
    output logic              upd_q,
    output logic [WORD_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
            hold_q <= '0;
            byp_q  <= 1'b0;
            upd_q  <= 1'b0;
        end else if (we) begin
            wait_q <= wdata[WAIT_LSB +: CNT_W];
            hold_q <= wdata[HOLD_LSB +: CNT_W];
            byp_q  <= wdata[BYP_BIT];
            upd_q  <= wdata[UPD_BIT];
        end else if (apply) begin
            upd_q  <= 1'b0;
        end
    end

    always_comb begin
        rdata                      = '0;
        rdata[WAIT_LSB +: CNT_W]   = wait_q;
        rdata[HOLD_LSB +: CNT_W]   = hold_q;
        rdata[BYP_BIT]             = byp_q;
        rdata[UPD_BIT]             = upd_q;
    end
endmodule

// File: rtl/wh_div_seq.sv
module wh_div_seq
    import wh_div_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] new_wait,
    input  logic [CNT_W-1:0] new_hold,
    input  logic             byp_req,
    input  logic             upd_req,
    output logic             apply,
    output logic             div_q,
    output logic             pass_q
);
    ph_e              st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [CNT_W-1:0] act_wait, act_wait_n;
    logic [CNT_W-1:0] act_hold, act_hold_n;
    logic             boundary;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= PH_HIGH;
            cnt      <= '0;
            act_wait <= '0;
            act_hold <= '0;
        end else begin
            st       <= st_n;
            cnt      <= cnt_n;
            act_wait <= act_wait_n;
            act_hold <= act_hold_n;
        end
    end

    always_comb begin
        boundary   = ((st == PH_LOW) && (cnt == act_hold)) || (st == PH_PASS);
        apply      = boundary && upd_req;
        st_n       = st;
        cnt_n      = cnt;
        act_wait_n = apply ? new_wait : act_wait;
        act_hold_n = apply ? new_hold : act_hold;
        unique case (st)
            PH_HIGH: begin
                if (cnt == act_wait) begin
                    st_n  = PH_LOW;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            PH_LOW: begin
                if (cnt == act_hold) begin
                    st_n  = byp_req ? PH_PASS : PH_HIGH;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            PH_PASS: begin
                cnt_n = '0;
                if (!byp_req) st_n = PH_HIGH;
            end
            default: begin
                st_n  = PH_HIGH;
                cnt_n = '0;
            end
        endcase
    end

    // outputs, registered from the next state so they never glitch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= 1'b1;
            pass_q <= 1'b0;
        end else begin
            div_q  <= (st_n == PH_HIGH);
            pass_q <= (st_n == PH_PASS);
        end
    end
endmodule

// File: rtl/wh_div_outmux.sv
module wh_div_outmux (
    input  logic clk,
    input  logic pass_sel,
    input  logic div_in,
    output logic clk_out
);
    always_comb clk_out = pass_sel ? clk : div_in;
endmodule

// File: rtl/wh_clock_divider.sv
module wh_clock_divider
    import wh_div_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        clk_out
);
    logic [CNT_W-1:0] wait_q, hold_q;
    logic             byp_q, upd_q;
    logic             apply_now, div_now, pass_now;

    wh_div_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .apply(apply_now), .wait_q(wait_q), .hold_q(hold_q),
        .byp_q(byp_q), .upd_q(upd_q), .rdata(cfg_rdata)
    );

    wh_div_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .new_wait(wait_q), .new_hold(hold_q),
        .byp_req(byp_q), .upd_req(upd_q), .apply(apply_now),
        .div_q(div_now), .pass_q(pass_now)
    );

    wh_div_outmux u_mux (
        .clk(clk), .pass_sel(pass_now), .div_in(div_now), .clk_out(clk_out)
    );
endmodule

// File: rtl/wh_div_checker.sv
module wh_div_checker #(
    parameter int CNT_W = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [31:0] cfg_rdata,
    input logic        apply_now,
    input logic        pass_now,
    input logic        div_now
);
    localparam int MAXRUN = 1 << CNT_W;
    logic [CNT_W+1:0] run;
    logic             div_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= '0;
            div_d <= 1'b1;
        end else begin
            div_d <= div_now;
            if (pass_now || (div_now != div_d)) run <= 1;
            else if (run <= (CNT_W+2)'(MAXRUN)) run <= run + 1'b1;
        end
    end

    p_quiet_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !apply_now) |=> $stable(cfg_rdata));

    p_clear_on_apply_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_rdata[25]) |-> $past(apply_now));

    p_pass_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass_now) |-> !$past(div_now));

    p_pass_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pass_now) |-> div_now);

    p_run_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run <= (CNT_W+2)'(MAXRUN));
endmodule

bind wh_clock_divider wh_div_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
    .apply_now(apply_now), .pass_now(pass_now), .div_now(div_now)
);

// File: tb/test_wh_clock_divider.sv
module test_wh_clock_divider;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] rd4, rd3;
    logic        out4, out3;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    wh_clock_divider #(.CNT_W(4)) i_wh_clock_divider (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd4), .clk_out(out4));

    wh_clock_divider #(.CNT_W(3)) i_wh_clock_divider_w3 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd3), .clk_out(out3));

    function automatic logic [31:0] word(int w, int h, bit byp, bit upd);
        return (32'(h) << 20) | (32'(w) << 16) | (32'(byp) << 24) | (32'(upd) << 25);
    endfunction

    function automatic int wait_of(int ratio);
        return ratio / 2 - 1;
    endfunction

    function automatic int hold_of(int ratio);
        return ratio - wait_of(ratio) - 2;
    endfunction

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic poll_clear(bit sel);
        for (int i = 0; i < 80; i++) begin
            if (((sel ? rd3 : rd4) & 32'h0200_0000) == 0) break;
            @(negedge clk);
        end
    endtask

    task automatic measure(bit sel, output int hi, output int lo);
        logic prev, v;
        prev = 1'b1;
        hi = 0;
        lo = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); #1;
            v = sel ? out3 : out4;
            if (!prev && v) break;
            prev = v;
        end
        hi = 1;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #1;
            if ((sel ? out3 : out4) == 1'b1) hi++; else break;
        end
        lo = 1;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #1;
            if ((sel ? out3 : out4) == 1'b0) lo++; else break;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int hi, lo, w, h, r, bad;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);

        check("R1 reset word", rd4, 0);
        measure(0, hi, lo);
        check("R1 reset high", hi, 1);
        check("R1 reset low", lo, 1);

        // R2: masked readback, junk bits dropped
        wr(32'hC0A5_FFFF);
        check("R2 readback", rd4, 32'h00A5_0000);
        // R4: no request, period unchanged
        measure(0, hi, lo);
        check("R4 high unchanged", hi, 1);
        check("R4 low unchanged", lo, 1);

        // R5: request sets bit, then counts apply
        wr(word(5, 10, 0, 1));
        check("R5 pending bit", (rd4 >> 25) & 1, 1);
        poll_clear(0);
        check("R5 cleared", (rd4 >> 25) & 1, 0);
        measure(0, hi, lo);
        check("R5 new high", hi, 6);
        check("R5 new low", lo, 11);

        // R3: random ratios 2..32 plus the two extremes
        for (int k = 0; k < 12; k++) begin
            r = (k == 0) ? 2 : (k == 1) ? 32 : 2 + int'($urandom % 31);
            w = wait_of(r);
            h = hold_of(r);
            wr(word(w, h, 0, 1));
            poll_clear(0);
            measure(0, hi, lo);
            check("R3 high", hi, w + 1);
            check("R3 low", lo, h + 1);
            check("R3 period", hi + lo, r);
        end

        // R6: bypass follows source clock
        wr(word(3, 4, 1, 0));
        check("R6 bypass bit", (rd4 >> 24) & 1, 1);
        repeat (40) @(negedge clk);
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #2;
            if (out4 !== 1'b1) bad++;
            @(negedge clk); #2;
            if (out4 !== 1'b0) bad++;
        end
        check("R6 bypass follows clock", bad, 0);

        // R7: update during bypass applies next cycle
        wr(word(2, 1, 1, 1));
        @(posedge clk); #1;
        check("R7 applied in bypass", (rd4 >> 25) & 1, 0);

        // R6: leave bypass, counts loaded during bypass are used
        wr(word(2, 1, 0, 0));
        measure(0, hi, lo);
        check("R6 exit high", hi, 3);
        check("R6 exit low", lo, 2);

        // R8: narrow variant
        wr(word(15, 15, 0, 1));
        poll_clear(1);
        check("R8 narrow readback", rd3, 32'h0077_0000);
        measure(1, hi, lo);
        check("R8 narrow high", hi, 8);
        check("R8 narrow low", lo, 8);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule